// File: doc/BRIEF.md
# Prioritized Two-Bank Interrupt Controller

This block collects up to 32 interrupt inputs and presents them to a processor on two request lines: a normal request line and a fast request line. Each input first passes a per-source conditioning stage (optional inversion, then either level-following or capture until acknowledged). A per-source route bit then assigns it to one of two identical banks. Each bank holds its own enable mask and priority threshold. It produces a masked status vector, a "current" register naming the source to service, and a request line that is the OR of its masked status.

Software drives the block over a simple word-addressed register bus. Read data is combinational in the cycle the read is presented, and all state changes take effect on the following clock edge. The service loop reads the current register of a bank and handles that source. It then reads the bank's acknowledge register, whose read side effect releases the captured state of that source, and repeats until the bank's status reads zero.

Top module: `prio_intc`

## Requirements
- R1: After reset, both banks' enable masks are 0, both thresholds are 0xF, every polarity bit is 1, every capture bit is 0, every route bit is 0 and every source priority is 0. With all inputs low, irq_o and fiq_o are 0.
- R2: A write to enable-set (word 0x002 for the normal bank, 0x042 for the fast bank) sets the mask bits where write data is 1. A write to enable-clear (word 0x003 / 0x043) clears them. Bits where write data is 0 keep their value. A read of either word returns the mask.
- R3: Polarity register (word 0x080): bit i = 1 passes input i unchanged, and bit i = 0 inverts it. Raw status (word 0x001 or 0x041) returns the conditioned pending vector of all sources, before masking and routing.
- R4: Capture register (word 0x081): bit i = 0 makes source i follow its conditioned input. Bit i = 1 holds it pending from the first clock edge it is seen asserted until it is acknowledged.
- R5: Masked status of a bank (word 0x000 / 0x040) has bit i set when source i is pending, routed to that bank, enabled in that bank, and has a priority not above the bank threshold. irq_o and fiq_o are the OR of the respective masked status.
- R6: Current (word 0x008 / 0x048) returns the number of the masked-status source with the numerically lowest priority. Ties go to the lowest source number. It returns 0 when masked status is 0.
- R7: A read of the acknowledge word (0x00A / 0x04A) returns 0. On the next edge it clears the captured state of the source named by that bank's current register. A write to it has no effect.
- R8: The threshold (word 0x00B / 0x04B) is 4 bits wide. A source whose priority is numerically greater than the threshold is excluded from masked status and current. 0xF admits every priority.
- R9: Route register (word 0x082): bit i = 1 sends source i to the fast bank only, and bit i = 0 sends it to the normal bank only.
- R10: Source i has a 4-bit priority at word 0x0C0 + i. Only write data bits 3:0 are stored, and a read returns them zero-extended.

Word address = byte offset / 4. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt inputs |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Normal-bank request |
| fiq_o | output | 1 | Fast-bank request |

## Verification
The properties assume the bus issues at most one access per cycle, so only one bank's acknowledge can fire in a cycle. They also assume bus inputs are stable around the sampling edge. The bench drives every input at the falling edge and issues each access as a one-cycle strobe followed by an idle cycle. The capture-hold property assumes the capture select changes only through the bus. The bench writes it only while the affected sources are idle.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 10;

  // region = addr[9:6]
  localparam logic [3:0] RGN_IRQ  = 4'd0;
  localparam logic [3:0] RGN_FIQ  = 4'd1;
  localparam logic [3:0] RGN_CTL  = 4'd2;
  localparam logic [3:0] RGN_PRIO = 4'd3;

  // word offsets inside a bank
  localparam logic [5:0] OFS_STATUS = 6'h00;
  localparam logic [5:0] OFS_RAW    = 6'h01;
  localparam logic [5:0] OFS_EN_SET = 6'h02;
  localparam logic [5:0] OFS_EN_CLR = 6'h03;
  localparam logic [5:0] OFS_CUR    = 6'h08;
  localparam logic [5:0] OFS_ACK    = 6'h0A;
  localparam logic [5:0] OFS_THR    = 6'h0B;

  // word offsets inside control region
  localparam logic [5:0] OFS_INV    = 6'h00;
  localparam logic [5:0] OFS_STICKY = 6'h01;
  localparam logic [5:0] OFS_ROUTE  = 6'h02;
endpackage

// File: rtl/prio_intc_cond.sv
module prio_intc_cond #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] inv_sel_i,
  input  logic [N-1:0] sticky_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lat_o,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic cond, lat_q;
    assign cond = inv_sel_i[i] ? src_i[i] : ~src_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          lat_q <= 1'b0;
      else if (!sticky_i[i]) lat_q <= 1'b0;
      else                   lat_q <= (lat_q & ~clr_i[i]) | cond;
    end

    assign lat_o[i]  = lat_q;
    assign pend_o[i] = sticky_i[i] ? lat_q : cond;
  end
endmodule

// File: rtl/prio_intc_pick.sv
module prio_intc_pick #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o
);
  logic [PW-1:0] best;

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps lowest index on ties
      if (req_i[i] && (!valid_o || prio_i[i*PW +: PW] < best)) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        best    = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/prio_intc_bank.sv
module prio_intc_bank
  import prio_intc_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [5:0]        ofs_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      pend_i,
  input  logic [N-1:0]      route_i,
  input  logic [N*PW-1:0]   prio_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      ack_o,
  output logic              req_o
);
  logic [N-1:0]  en_q, thr_ok, status;
  logic [PW-1:0] thr_q;
  logic          cur_vld;
  logic [IW-1:0] cur_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      thr_q <= '1;
    end else if (sel_i && wr_i) begin
      case (ofs_i)
        OFS_EN_SET: en_q  <= en_q | wdata_i[N-1:0];
        OFS_EN_CLR: en_q  <= en_q & ~wdata_i[N-1:0];
        OFS_THR:    thr_q <= wdata_i[PW-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_thr
    assign thr_ok[i] = prio_i[i*PW +: PW] <= thr_q;
  end

  assign status = pend_i & route_i & en_q & thr_ok;
  assign req_o  = |status;
  assign en_o   = en_q;

  prio_intc_pick #(.N(N), .PW(PW)) u_pick (
    .req_i  (status),
    .prio_i (prio_i),
    .valid_o(cur_vld),
    .idx_o  (cur_idx)
  );

  always_comb begin
    ack_o = '0;
    if (sel_i && rd_i && ofs_i == OFS_ACK && cur_vld) ack_o[cur_idx] = 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (ofs_i)
        OFS_STATUS:          rdata_o = DATA_W'(status);
        OFS_RAW:             rdata_o = DATA_W'(pend_i);
        OFS_EN_SET,
        OFS_EN_CLR:          rdata_o = DATA_W'(en_q);
        OFS_CUR:             rdata_o = DATA_W'(cur_idx);
        OFS_THR:             rdata_o = DATA_W'(thr_q);
        default:             rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned IW = $clog2(NUM_SRC);

  logic [3:0]          rgn;
  logic [5:0]          ofs;
  logic                rd, wr;
  logic [NUM_SRC-1:0]  inv_q, sticky_q, route_q;
  logic [PRIO_W-1:0]   prio_q [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC-1:0]  pend, lat, ack_any;
  logic [NUM_SRC-1:0]  bank_en  [2];
  logic [NUM_SRC-1:0]  bank_ack [2];
  logic [1:0]          bank_req;
  logic [DATA_W-1:0]   bank_rd  [2];
  logic                prio_hit;

  assign rgn = addr_i[ADDR_W-1:6];
  assign ofs = addr_i[5:0];
  assign rd  = req_i & ~we_i;
  assign wr  = req_i & we_i;
  assign prio_hit = (rgn == RGN_PRIO) && (ofs < 6'(NUM_SRC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q    <= '1;
      sticky_q <= '0;
      route_q  <= '0;
    end else if (wr && rgn == RGN_CTL) begin
      case (ofs)
        OFS_INV:    inv_q    <= wdata_i[NUM_SRC-1:0];
        OFS_STICKY: sticky_q <= wdata_i[NUM_SRC-1:0];
        OFS_ROUTE:  route_q  <= wdata_i[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[i] <= '0;
      else if (wr && prio_hit && ofs[IW-1:0] == IW'(i)) prio_q[i] <= wdata_i[PRIO_W-1:0];
    end
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  prio_intc_cond #(.N(NUM_SRC)) u_cond (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .inv_sel_i(inv_q),
    .sticky_i (sticky_q),
    .clr_i    (ack_any),
    .lat_o    (lat),
    .pend_o   (pend)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    prio_intc_bank #(.N(NUM_SRC), .PW(PRIO_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (rgn == 4'(b)),
      .rd_i   (rd),
      .wr_i   (wr),
      .ofs_i  (ofs),
      .wdata_i(wdata_i),
      .pend_i (pend),
      .route_i(b == 1 ? route_q : ~route_q),
      .prio_i (prio_flat),
      .rdata_o(bank_rd[b]),
      .en_o   (bank_en[b]),
      .ack_o  (bank_ack[b]),
      .req_o  (bank_req[b])
    );
  end

  assign ack_any = bank_ack[0] | bank_ack[1];
  assign irq_o   = bank_req[0];
  assign fiq_o   = bank_req[1];

  always_comb begin
    rdata_o = '0;
    unique case (rgn)
      RGN_IRQ: rdata_o = bank_rd[0];
      RGN_FIQ: rdata_o = bank_rd[1];
      RGN_CTL: begin
        case (ofs)
          OFS_INV:    rdata_o = DATA_W'(inv_q);
          OFS_STICKY: rdata_o = DATA_W'(sticky_q);
          OFS_ROUTE:  rdata_o = DATA_W'(route_q);
          default:    rdata_o = '0;
        endcase
      end
      RGN_PRIO: rdata_o = prio_hit ? DATA_W'(prio_q[ofs[IW-1:0]]) : '0;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import prio_intc_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [N-1:0]      irq_en_i,
  input logic [N-1:0]      lat_i,
  input logic [N-1:0]      sticky_i,
  input logic [N-1:0]      ack_i,
  input logic              irq_o,
  input logic              fiq_o
);
  a_r2_set_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 10'h002)
      |=> ((irq_en_i & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));

  a_r2_clr_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 10'h003)
      |=> ((irq_en_i & $past(wdata_i[N-1:0])) == '0));

  // R4: a captured source drops only through an acknowledge
  a_r4_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~lat_i) & $past(lat_i & ~ack_i & sticky_i) & sticky_i) == '0);

  a_r5_no_irq_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o);

  a_r7_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_i));

  a_r7_ack_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i != '0) |-> (req_i && !we_i));

  a_r1_lines_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({irq_o, fiq_o}));
endmodule

bind prio_intc prio_intc_chk #(.N(NUM_SRC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_en_i(bank_en[0]),
  .lat_i   (lat),
  .sticky_i(sticky_q),
  .ack_i   (ack_any),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  logic        clk = 0, rst_n = 0;
  logic [31:0] src = '0;
  logic        req = 0, we = 0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, fiq;
  int          nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  prio_intc u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  // {src, en, thr, exp_status, exp_cur}; prio: 3->2, 5->2, 10->1, 20->9, others 15
  localparam logic [104:0] VEC [8] = '{
    {32'h0000_0000, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, 5'd0},
    {32'h0000_0028, 32'hFFFF_FFFF, 4'hF, 32'h0000_0028, 5'd3},
    {32'h0000_0428, 32'hFFFF_FFFF, 4'hF, 32'h0000_0428, 5'd10},
    {32'h0010_0400, 32'h0010_0000, 4'hF, 32'h0010_0000, 5'd20},
    {32'h0010_0001, 32'hFFFF_FFFF, 4'h8, 32'h0000_0000, 5'd0},
    {32'h0010_0021, 32'hFFFF_FFFF, 4'h9, 32'h0010_0020, 5'd5},
    {32'h8000_0001, 32'hFFFF_FFFF, 4'hF, 32'h8000_0001, 5'd0},
    {32'h8000_0000, 32'hFFFF_FFFF, 4'hF, 32'h8000_0000, 5'd31}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  initial begin
    #(20 * 100000);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(10'h002, d); check("R1 irq enable", d, 0);
    rd(10'h042, d); check("R1 fiq enable", d, 0);
    rd(10'h00B, d); check("R1 irq thr", d, 32'hF);
    rd(10'h04B, d); check("R1 fiq thr", d, 32'hF);
    rd(10'h080, d); check("R1 polarity", d, 32'hFFFF_FFFF);
    rd(10'h081, d); check("R1 capture", d, 0);
    rd(10'h082, d); check("R1 route", d, 0);
    rd(10'h0C7, d); check("R1 prio7", d, 0);
    check("R1 lines", {30'd0, fiq, irq}, 0);

    // R10 priorities
    for (int i = 0; i < 32; i++) wr(10'h0C0 + 10'(i), 32'hF);
    wr(10'h0C3, 2); wr(10'h0C5, 2); wr(10'h0CA, 32'hFFFF_FFF1); wr(10'h0D4, 9);
    rd(10'h0CA, d); check("R10 prio width", d, 1);
    rd(10'h0C5, d); check("R10 prio readback", d, 2);

    // R2 enable set/clear
    wr(10'h002, 32'h0000_00F0);
    wr(10'h002, 32'h0000_0F00);
    wr(10'h003, 32'h0000_0330);
    rd(10'h002, d); check("R2 set/clr", d, 32'h0000_0CC0);
    rd(10'h003, d); check("R2 clr word read", d, 32'h0000_0CC0);

    // R5 R6 R8 table
    for (int v = 0; v < 8; v++) begin
      wr(10'h003, 32'hFFFF_FFFF);
      wr(10'h002, VEC[v][72:41]);
      wr(10'h00B, {28'd0, VEC[v][40:37]});
      @(negedge clk); src = VEC[v][104:73];
      rd(10'h000, d); check($sformatf("R5 R8 status v%0d", v), d, VEC[v][36:5]);
      rd(10'h008, d); check($sformatf("R6 current v%0d", v), d, {27'd0, VEC[v][4:0]});
      check($sformatf("R5 irq line v%0d", v), {31'd0, irq}, {31'd0, VEC[v][36:5] != 0});
    end
    @(negedge clk); src = '0;
    wr(10'h003, 32'hFFFF_FFFF);

    // R3 polarity and raw status
    wr(10'h080, ~32'h0000_0080);
    rd(10'h001, d); check("R3 inverted low input", d, 32'h0000_0080);
    @(negedge clk); src = 32'h0000_0080;
    rd(10'h001, d); check("R3 inverted high input", d, 0);
    @(negedge clk); src = '0;
    wr(10'h080, 32'hFFFF_FFFF);

    // R4 capture vs level
    wr(10'h081, 32'h0000_5000);
    wr(10'h002, 32'h0000_7000);
    @(negedge clk); src = 32'h0000_7000;
    @(negedge clk); src = '0;
    rd(10'h000, d); check("R4 captured vs level", d, 32'h0000_5000);
    rd(10'h008, d); check("R6 tie lowest", d, 12);

    // R7 acknowledge
    rd(10'h00A, d); check("R7 ack data", d, 0);
    rd(10'h000, d); check("R7 one cleared", d, 32'h0000_4000);
    wr(10'h00A, 32'hFFFF_FFFF);
    rd(10'h000, d); check("R7 write ignored", d, 32'h0000_4000);
    rd(10'h00A, d);
    rd(10'h000, d); check("R7 second ack", d, 0);
    check("R5 irq low", {31'd0, irq}, 0);

    // R9 route to fast bank
    wr(10'h082, 32'h0000_4000);
    wr(10'h042, 32'h0000_4000);
    @(negedge clk); src = 32'h0000_4000;
    @(negedge clk); src = '0;
    rd(10'h000, d); check("R9 normal bank excluded", d, 0);
    rd(10'h040, d); check("R9 fast status", d, 32'h0000_4000);
    rd(10'h048, d); check("R9 fast current", d, 14);
    check("R9 lines", {30'd0, fiq, irq}, 32'h2);
    rd(10'h04A, d);
    rd(10'h040, d); check("R9 R7 fast ack", d, 0);
    check("R9 fiq low", {31'd0, fiq}, 0);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule